// File: doc/BRIEF.md
# Memory-Mapped GPIO Peripheral Bus

This block sits between a 16-bit CPU data port and the rest of its data space. The lowest 16K words go to an external data RAM. The words directly above the RAM hold three small peripherals: a switch input port, an LED output register and a seven-segment output register. The block decodes every CPU address. It passes RAM accesses through to the RAM-side port and serves peripheral accesses from its own registers. Addresses that fall outside all of these regions read as zero and ignore writes.

The board pins are active-low. The block inverts the switch pins on the way in and inverts both output registers on the way out. Software therefore works only with active-high values. A switch that is on reads as 1, and writing 1 to a bit turns its LED or segment on. The switch pins pass through a two-stage synchronizer before they reach the read bus.

Top module: `gpio_bus`

## Requirements
- R1: For an address below 16384, `ram_addr_o` equals the low 14 address bits, `ram_wdata_o` equals `wdata_i`, `ram_we_o` follows `we_i`, and `rdata_o` returns `ram_rdata_i` in the same cycle.
- R2: `ram_we_o` stays low for every address of 16384 or above, whatever `we_i` is.
- R3: A read of address 16384 returns the inverted switch pins, zero-extended. A pin change made before rising edge N is not visible after edge N and is visible after edge N+1.
- R4: A write to address 16385 loads `wdata_i` into the LED register on that rising edge. `led_no` is the bitwise inverse of the register, and a read of 16385 returns the register.
- R5: A write to address 16386 loads `wdata_i[7:0]` into the segment register on that rising edge (bits 6:0 are the segments, bit 7 is the decimal point). `seg_no` is its inverse, and a read of 16386 returns the register zero-extended.
- R6: While `rst_ni` is low, both output registers clear, so `led_no` and `seg_no` are all ones and reads of 16385 and 16386 return 0.
- R7: A write to 16384 or to any address above 16386 leaves the LED and segment registers, their pins and the switch read value unchanged.
- R8: A read of any address from 16387 to 65535 returns 0.
- R9: When the same cycle both reads and writes an output register, `rdata_o` returns the old value in that cycle and the new value after the edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | 16 | CPU word address |
| wdata_i | input | 16 | CPU write data |
| we_i | input | 1 | CPU write enable |
| rdata_o | output | 16 | CPU read data |
| ram_addr_o | output | 14 | RAM word address |
| ram_wdata_o | output | 16 | RAM write data |
| ram_we_o | output | 1 | RAM write enable |
| ram_rdata_i | input | 16 | RAM read data |
| sw_ni | input | 16 | Switch pins, active low |
| led_no | output | 16 | LED pins, active low |
| seg_no | output | 8 | Seven segments plus decimal point, active low |

## Verification
Two functions can fall in the same cycle: the combinational readback of an output register, and a write to that same register. The bench holds the LED address with write enable high and new data on the bus. Before the edge it expects the old register value on `rdata_o`. After the edge it expects the new value on `rdata_o` and its inverse on `led_no`. The switch synchronizer is judged in a similar way: the bench samples between the first and second edges after a pin change, to confirm that the change is not seen one cycle early.

// File: rtl/gpio_bus_pkg.sv
package gpio_bus_pkg;
  typedef enum logic [2:0] {
    SEL_RAM,
    SEL_SW,
    SEL_LED,
    SEL_SEG,
    SEL_NONE
  } sel_e;

  // word offsets above the RAM top
  localparam int unsigned SW_OFS  = 0;
  localparam int unsigned LED_OFS = 1;
  localparam int unsigned SEG_OFS = 2;
endpackage

// File: rtl/gpio_addr_dec.sv
module gpio_addr_dec
  import gpio_bus_pkg::*;
#(
  parameter int unsigned ADDR_W = 16,
  parameter int unsigned RAM_AW = 14
) (
  input  logic [ADDR_W-1:0] addr_i,
  output sel_e              sel_o
);
  localparam logic [ADDR_W-1:0] PERIPH_BASE = ADDR_W'(1) << RAM_AW;

  logic [ADDR_W-1:0] ofs;
  assign ofs = addr_i - PERIPH_BASE;

  always_comb begin
    if (addr_i < PERIPH_BASE)            sel_o = SEL_RAM;
    else if (ofs == ADDR_W'(SW_OFS))     sel_o = SEL_SW;
    else if (ofs == ADDR_W'(LED_OFS))    sel_o = SEL_LED;
    else if (ofs == ADDR_W'(SEG_OFS))    sel_o = SEL_SEG;
    else                                 sel_o = SEL_NONE;
  end
endmodule

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int unsigned W      = 16,
  parameter int unsigned STAGES = 2,
  parameter logic        RST_V  = 1'b1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stage_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)     stage_q[s] <= {W{RST_V}};
      else if (s == 0) stage_q[s] <= d_i;
      else             stage_q[s] <= stage_q[(s == 0) ? 0 : s-1];
    end
  end

  assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/gpio_out_reg.sv
module gpio_out_reg #(
  parameter int unsigned W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         we_i,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o,
  output logic [W-1:0] pin_no
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   q_o <= '0;
    else if (we_i) q_o <= d_i;
  end

  assign pin_no = ~q_o;
endmodule

// File: rtl/gpio_bus.sv
module gpio_bus
  import gpio_bus_pkg::*;
#(
  parameter int unsigned ADDR_W = 16,
  parameter int unsigned DATA_W = 16,
  parameter int unsigned RAM_AW = 14,
  parameter int unsigned SW_W   = 16,
  parameter int unsigned LED_W  = 16,
  parameter int unsigned SEG_W  = 8,
  parameter int unsigned SYNC_N = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              we_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic [RAM_AW-1:0] ram_addr_o,
  output logic [DATA_W-1:0] ram_wdata_o,
  output logic              ram_we_o,
  input  logic [DATA_W-1:0] ram_rdata_i,
  input  logic [SW_W-1:0]   sw_ni,
  output logic [LED_W-1:0]  led_no,
  output logic [SEG_W-1:0]  seg_no
);
  sel_e             sel;
  logic [SW_W-1:0]  sw_pin_s;
  logic [LED_W-1:0] led_q;
  logic [SEG_W-1:0] seg_q;

  gpio_addr_dec #(.ADDR_W(ADDR_W), .RAM_AW(RAM_AW)) i_dec (
    .addr_i(addr_i),
    .sel_o (sel)
  );

  // pins idle high (switch off), so reset to the off level
  gpio_sync #(.W(SW_W), .STAGES(SYNC_N), .RST_V(1'b1)) i_sw_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (sw_ni),
    .q_o   (sw_pin_s)
  );

  gpio_out_reg #(.W(LED_W)) i_led (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .we_i  (we_i && sel == SEL_LED),
    .d_i   (wdata_i[LED_W-1:0]),
    .q_o   (led_q),
    .pin_no(led_no)
  );

  gpio_out_reg #(.W(SEG_W)) i_seg (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .we_i  (we_i && sel == SEL_SEG),
    .d_i   (wdata_i[SEG_W-1:0]),
    .q_o   (seg_q),
    .pin_no(seg_no)
  );

  assign ram_addr_o  = addr_i[RAM_AW-1:0];
  assign ram_wdata_o = wdata_i;
  assign ram_we_o    = we_i && (sel == SEL_RAM);

  always_comb begin
    unique case (sel)
      SEL_RAM: rdata_o = ram_rdata_i;
      SEL_SW:  rdata_o = DATA_W'(~sw_pin_s);
      SEL_LED: rdata_o = DATA_W'(led_q);
      SEL_SEG: rdata_o = DATA_W'(seg_q);
      default: rdata_o = '0;
    endcase
  end
endmodule

// File: rtl/gpio_bus_chk.sv
module gpio_bus_chk #(
  parameter int unsigned ADDR_W = 16,
  parameter int unsigned DATA_W = 16,
  parameter int unsigned RAM_AW = 14,
  parameter int unsigned LED_W  = 16,
  parameter int unsigned SEG_W  = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [ADDR_W-1:0] addr_i,
  input logic [DATA_W-1:0] wdata_i,
  input logic              we_i,
  input logic [DATA_W-1:0] rdata_o,
  input logic              ram_we_o,
  input logic [LED_W-1:0]  led_no,
  input logic [SEG_W-1:0]  seg_no
);
  localparam logic [ADDR_W-1:0] BASE_A = ADDR_W'(1) << RAM_AW;
  localparam logic [ADDR_W-1:0] LED_A  = BASE_A + ADDR_W'(1);
  localparam logic [ADDR_W-1:0] SEG_A  = BASE_A + ADDR_W'(2);

  assert_ram_we_gated_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (addr_i >= BASE_A) |-> !ram_we_o);

  assert_led_load_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && addr_i == LED_A) |=> (led_no == ~$past(wdata_i[LED_W-1:0])));

  assert_seg_load_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && addr_i == SEG_A) |=> (seg_no == ~$past(wdata_i[SEG_W-1:0])));

  assert_led_hold_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(we_i && addr_i == LED_A) |=> $stable(led_no));

  assert_seg_hold_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(we_i && addr_i == SEG_A) |=> $stable(seg_no));

  assert_unmapped_zero_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (addr_i > SEG_A) |-> (rdata_o == '0));
endmodule

bind gpio_bus gpio_bus_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .RAM_AW(RAM_AW), .LED_W(LED_W), .SEG_W(SEG_W)
) i_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .addr_i  (addr_i),
  .wdata_i (wdata_i),
  .we_i    (we_i),
  .rdata_o (rdata_o),
  .ram_we_o(ram_we_o),
  .led_no  (led_no),
  .seg_no  (seg_no)
);

// File: tb/test_gpio_bus.sv
module test_gpio_bus;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [15:0] addr_i = '0;
  logic [15:0] wdata_i = '0;
  logic        we_i = 1'b0;
  logic [15:0] rdata_o;
  logic [13:0] ram_addr_o;
  logic [15:0] ram_wdata_o;
  logic        ram_we_o;
  logic [15:0] ram_rdata_i;
  logic [15:0] sw_ni = '1;
  logic [15:0] led_no;
  logic [7:0]  seg_no;

  int errors = 0;
  int checks = 0;

  always #2.5 clk_i = ~clk_i;

  // RAM model: data is a fixed function of the address
  assign ram_rdata_i = {2'b00, ram_addr_o} ^ 16'h5A5A;

  gpio_bus i_gpio_bus (
    .clk_i(clk_i), .rst_ni(rst_ni), .addr_i(addr_i), .wdata_i(wdata_i), .we_i(we_i),
    .rdata_o(rdata_o), .ram_addr_o(ram_addr_o), .ram_wdata_o(ram_wdata_o),
    .ram_we_o(ram_we_o), .ram_rdata_i(ram_rdata_i), .sw_ni(sw_ni),
    .led_no(led_no), .seg_no(seg_no)
  );

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  // {we, addr, wdata, expected rdata, requirement number}
  localparam int NV = 13;
  localparam logic [52:0] VEC [NV] = '{
    {1'b1, 16'd16385, 16'hA5C3, 16'h0000, 4'd4},  // R4 write LED
    {1'b0, 16'd16385, 16'h0000, 16'hA5C3, 4'd4},  // R4 read LED
    {1'b1, 16'd16386, 16'h12FF, 16'h0000, 4'd5},  // R5 write segment
    {1'b0, 16'd16386, 16'h0000, 16'h00FF, 4'd5},  // R5 read segment
    {1'b1, 16'd16384, 16'hFFFF, 16'h0000, 4'd7},  // R7 write switch port
    {1'b0, 16'd16385, 16'h0000, 16'hA5C3, 4'd7},
    {1'b0, 16'd16386, 16'h0000, 16'h00FF, 4'd7},
    {1'b1, 16'd16387, 16'h1234, 16'h0000, 4'd8},  // R8 write unmapped
    {1'b0, 16'd16387, 16'h0000, 16'h0000, 4'd8},
    {1'b0, 16'hFFFF,  16'h0000, 16'h0000, 4'd8},
    {1'b0, 16'd100,   16'h0000, 16'h5A3E, 4'd1},  // R1 RAM read
    {1'b0, 16'd16383, 16'h0000, 16'h65A5, 4'd1},
    {1'b0, 16'd16384, 16'h0000, 16'h0000, 4'd7}
  };

  initial begin
    repeat (10000) @(posedge clk_i);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk_i);
    @(negedge clk_i);
    // R6 reset state
    check("R6 led pins", led_no, 16'hFFFF);
    check("R6 seg pins", {8'h00, seg_no}, 16'h00FF);
    addr_i = 16'd16385; #1 check("R6 led read", rdata_o, 16'h0000);
    addr_i = 16'd16386; #1 check("R6 seg read", rdata_o, 16'h0000);
    rst_ni = 1'b1;

    for (int i = 0; i < NV; i++) begin
      @(negedge clk_i);
      we_i    = VEC[i][52];
      addr_i  = VEC[i][51:36];
      wdata_i = VEC[i][35:20];
      if (VEC[i][52]) begin
        @(posedge clk_i);
      end else begin
        #1;
        checks++;
        if (rdata_o !== VEC[i][19:4]) begin
          errors++;
          $display("FAIL R%0d vector %0d: actual=%h expected=%h",
                   VEC[i][3:0], i, rdata_o, VEC[i][19:4]);
        end
      end
    end

    @(negedge clk_i);
    we_i = 1'b0;
    check("R4 led pins", led_no, 16'h5A3C);
    check("R5 seg pins", {8'h00, seg_no}, 16'h0000);

    // R3 two-edge synchronizer latency
    addr_i = 16'd16384;
    sw_ni  = ~16'h00F3;
    @(posedge clk_i); @(negedge clk_i);
    check("R3 after one edge", rdata_o, 16'h0000);
    @(posedge clk_i); @(negedge clk_i);
    check("R3 after two edges", rdata_o, 16'h00F3);

    // R1 RAM write pass-through
    addr_i = 16'h1234; wdata_i = 16'hBEEF; we_i = 1'b1;
    #1;
    check("R1 ram we", {15'd0, ram_we_o}, 16'h0001);
    check("R1 ram addr", {2'b00, ram_addr_o}, 16'h1234);
    check("R1 ram wdata", ram_wdata_o, 16'hBEEF);

    // R2 gated above RAM
    @(negedge clk_i);
    addr_i = 16'h8000; #1 check("R2 high address", {15'd0, ram_we_o}, 16'h0000);
    addr_i = 16'd16384; #1 check("R2 switch address", {15'd0, ram_we_o}, 16'h0000);
    @(negedge clk_i);
    we_i = 1'b0;
    check("R7 led pins after ignored writes", led_no, 16'h5A3C);

    // R9 read and write of the same register in one cycle
    @(negedge clk_i);
    addr_i = 16'd16385; wdata_i = 16'h0F0F; we_i = 1'b1;
    #1 check("R9 old value before edge", rdata_o, 16'hA5C3);
    @(posedge clk_i); @(negedge clk_i);
    we_i = 1'b0;
    check("R9 new value after edge", rdata_o, 16'h0F0F);
    check("R9 led pins after edge", led_no, 16'hF0F0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule